// File: doc/BRIEF.md
# Full-Speed Serial Bus Line Encoder

This block sits between a packet engine and the line driver of a full-speed serial bus port. The engine hands over a packet as a stream of bytes, with a flag on the final byte. The encoder turns that stream into line states, one per bit period. For each packet it first emits the fixed synchronisation pattern. It then sends every payload bit least-significant bit first. Each payload bit passes through bit stuffing and NRZI coding: a 0 toggles the line and a 1 holds it. The packet closes with an end-of-packet sequence, after which the driver is released. A bit-rate strobe from the surrounding logic paces all activity. Between strobes the outputs hold.

Bytes enter over a valid/ready interface with back-pressure. `in_ready` is asserted only in a clock cycle that carries `bit_stb`. A byte transfers in a cycle where both `in_valid` and `in_ready` are high. Within a packet, the engine must offer the next byte in the strobe cycle where it is requested. If it does not, the encoder closes the packet at that point. Once a transfer has taken a byte flagged as last, no further byte is requested until the line has been idle for the required gap. PID and CRC fields are part of the byte stream and are not generated here.

Top module: `fs_line_encoder`

## Requirements
- R1: During and after reset, before any packet, all four line outputs (`line_j`, `line_k`, `line_se0`, `line_oe`) are low, and `in_ready` is low while `bit_stb` is low.
- R2: A packet starts in the strobe cycle where a byte transfers while idle. That bit period and the next seven show the states K J K J K J K K. The first byte is taken in the first of those periods.
- R3: Payload bits follow the sync field least-significant bit first. A 0 bit is sent as a change between J and K from the previous period, and a 1 bit as the same state. The coder starts from J at the beginning of the sync field.
- R4: After six consecutive payload 1 bits, an extra 0 bit is sent, which means the line state toggles. This extra bit resets the run count. This also happens when the sixth 1 is the final payload bit, in which case the extra bit comes before the end-of-packet sequence.
- R5: `in_ready` is high only in cycles with `bit_stb` high. It is low during a stuffed bit. Each later byte of a packet is taken in the bit period in which its bit 0 goes out.
- R6: After the last payload bit (and any stuffed bit), SE0 is driven for two bit periods and J for one. In the following period `line_oe` goes low and all line-state outputs are low.
- R7: After release, at least two bit periods pass with the line released and `in_ready` low before the next sync field can begin. The next packet begins in the third period if a byte is offered.
- R8: Outputs change only on a clock edge where `bit_stb` is high. While `line_oe` is high, exactly one of `line_j`, `line_k`, `line_se0` is high.
- R9: If no byte is offered in a strobe cycle where the next byte of an unfinished packet is requested, that period starts the end-of-packet sequence of R6. No byte is transferred in that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle pulse per bit period |
| in_valid | input | 1 | Byte offered by the packet engine |
| in_data | input | 8 | Byte value, bit 0 sent first |
| in_last | input | 1 | Offered byte is the final byte of the packet |
| in_ready | output | 1 | Byte taken in this cycle when in_valid is high |
| line_j | output | 1 | Drive J state |
| line_k | output | 1 | Drive K state |
| line_se0 | output | 1 | Drive single-ended zero |
| line_oe | output | 1 | Line driver enable |

## Verification
The hardest situation to reach from the ports is a run of ones that crosses a byte boundary or ends on the final payload bit. In these cases the stuffed bit either delays the request for the next byte or pushes back the end-of-packet sequence. The stimulus sweeps every single-byte value, which covers all possible end-of-packet stuff positions. It also runs a sweep of two-byte packets and hand-picked sequences such as 0xC0 followed by 0x0F, which places six ones exactly across a byte boundary. The first byte of the next packet is offered during the idle gap, so that any premature request shows up at the ports.

// File: rtl/fs_enc_pkg.sv
package fs_enc_pkg;
  // Kind of symbol the sequencer asks the line coder to emit this bit period.
  typedef enum logic [1:0] {
    SYM_REL = 2'd0,
    SYM_BIT = 2'd1,
    SYM_SE0 = 2'd2,
    SYM_J   = 2'd3
  } sym_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_DATA = 2'd2,
    ST_EOP  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/fs_enc_stuffer.sv
module fs_enc_stuffer #(
  parameter int RUN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  input  logic bit_val,
  output logic stuff_due
);
  localparam int CW = $clog2(RUN + 1);

  logic [CW-1:0] ones_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
    end else if (clr) begin
      ones_q <= '0;
    end else if (adv) begin
      ones_q <= bit_val ? ones_q + CW'(1) : '0;
    end
  end

  assign stuff_due = (ones_q == CW'(RUN));
endmodule

// File: rtl/fs_enc_nrzi.sv
module fs_enc_nrzi
  import fs_enc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  sym_e sym,
  input  logic bit_val,
  output logic line_j,
  output logic line_k,
  output logic line_se0,
  output logic line_oe
);
  // lvl_q: 1 means J, 0 means K; returns to J whenever the line is not coding.
  logic lvl_q;
  logic lvl_nxt;

  assign lvl_nxt = bit_val ? lvl_q : ~lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q    <= 1'b1;
      line_j   <= 1'b0;
      line_k   <= 1'b0;
      line_se0 <= 1'b0;
      line_oe  <= 1'b0;
    end else if (stb) begin
      case (sym)
        SYM_BIT: begin
          lvl_q    <= lvl_nxt;
          line_j   <= lvl_nxt;
          line_k   <= ~lvl_nxt;
          line_se0 <= 1'b0;
          line_oe  <= 1'b1;
        end
        SYM_SE0: begin
          lvl_q    <= 1'b1;
          line_j   <= 1'b0;
          line_k   <= 1'b0;
          line_se0 <= 1'b1;
          line_oe  <= 1'b1;
        end
        SYM_J: begin
          lvl_q    <= 1'b1;
          line_j   <= 1'b1;
          line_k   <= 1'b0;
          line_se0 <= 1'b0;
          line_oe  <= 1'b1;
        end
        default: begin
          lvl_q    <= 1'b1;
          line_j   <= 1'b0;
          line_k   <= 1'b0;
          line_se0 <= 1'b0;
          line_oe  <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/fs_enc_seq.sv
module fs_enc_seq
  import fs_enc_pkg::*;
#(
  parameter int                DATA_W       = 8,
  parameter int                SYNC_LEN     = 8,
  parameter logic [SYNC_LEN-1:0] SYNC_PAT   = 8'h80,
  parameter int                EOP_SE0_BITS = 2,
  parameter int                GAP_BITS     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic              stuff_due,
  output logic              in_ready,
  output sym_e              sym,
  output logic              sym_bit,
  output logic              pay_adv,
  output logic              pay_clr
);
  localparam int LW = $clog2(DATA_W + 1);
  localparam int SW = (SYNC_LEN > 1) ? $clog2(SYNC_LEN) : 1;
  localparam int EW = $clog2(EOP_SE0_BITS + 1);
  localparam int GW = $clog2(GAP_BITS + 1);

  seq_state_e        state_q, state_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [LW-1:0]     left_q, left_d;
  logic              last_q, last_d;
  logic [SW-1:0]     sidx_q, sidx_d;
  logic [EW-1:0]     eop_q, eop_d;
  logic [GW-1:0]     gap_q, gap_d;

  logic need_byte;
  logic gap_ok;

  assign need_byte = (left_q == '0);
  assign gap_ok    = (gap_q == GW'(GAP_BITS));
  assign pay_clr   = (state_q != ST_DATA);

  always_comb begin
    state_d  = state_q;
    sh_d     = sh_q;
    left_d   = left_q;
    last_d   = last_q;
    sidx_d   = sidx_q;
    eop_d    = eop_q;
    gap_d    = gap_q;
    sym      = SYM_REL;
    sym_bit  = 1'b0;
    pay_adv  = 1'b0;
    in_ready = 1'b0;

    case (state_q)
      ST_IDLE: begin
        in_ready = bit_stb && gap_ok;
        if (bit_stb) begin
          if (gap_ok && in_valid) begin
            sym     = SYM_BIT;
            sym_bit = SYNC_PAT[0];
            state_d = ST_SYNC;
            sidx_d  = SW'(1);
            sh_d    = in_data;
            left_d  = LW'(DATA_W);
            last_d  = in_last;
          end else if (!gap_ok) begin
            gap_d = gap_q + GW'(1);
          end
        end
      end

      ST_SYNC: begin
        if (bit_stb) begin
          sym     = SYM_BIT;
          sym_bit = SYNC_PAT[sidx_q];
          if (sidx_q == SW'(SYNC_LEN - 1)) begin
            state_d = ST_DATA;
          end else begin
            sidx_d = sidx_q + SW'(1);
          end
        end
      end

      ST_DATA: begin
        in_ready = bit_stb && !stuff_due && need_byte && !last_q;
        if (bit_stb) begin
          if (stuff_due) begin
            sym     = SYM_BIT;
            sym_bit = 1'b0;
            pay_adv = 1'b1;
          end else if (need_byte && (last_q || !in_valid)) begin
            sym     = SYM_SE0;
            state_d = ST_EOP;
            eop_d   = EW'(1);
          end else if (need_byte) begin
            sym     = SYM_BIT;
            sym_bit = in_data[0];
            pay_adv = 1'b1;
            sh_d    = in_data >> 1;
            left_d  = LW'(DATA_W - 1);
            last_d  = in_last;
          end else begin
            sym     = SYM_BIT;
            sym_bit = sh_q[0];
            pay_adv = 1'b1;
            sh_d    = sh_q >> 1;
            left_d  = left_q - LW'(1);
          end
        end
      end

      default: begin
        if (bit_stb) begin
          if (eop_q < EW'(EOP_SE0_BITS)) begin
            sym   = SYM_SE0;
            eop_d = eop_q + EW'(1);
          end else begin
            sym     = SYM_J;
            state_d = ST_IDLE;
            gap_d   = '0;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      left_q  <= '0;
      last_q  <= 1'b0;
      sidx_q  <= '0;
      eop_q   <= '0;
      gap_q   <= GW'(GAP_BITS);
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      left_q  <= left_d;
      last_q  <= last_d;
      sidx_q  <= sidx_d;
      eop_q   <= eop_d;
      gap_q   <= gap_d;
    end
  end
endmodule

// File: rtl/fs_line_encoder.sv
module fs_line_encoder
  import fs_enc_pkg::*;
#(
  parameter int                  DATA_W       = 8,
  parameter int                  STUFF_RUN    = 6,
  parameter int                  SYNC_LEN     = 8,
  parameter logic [SYNC_LEN-1:0] SYNC_PAT     = 8'h80,
  parameter int                  EOP_SE0_BITS = 2,
  parameter int                  GAP_BITS     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              line_j,
  output logic              line_k,
  output logic              line_se0,
  output logic              line_oe
);
  sym_e sym;
  logic sym_bit;
  logic pay_adv;
  logic pay_clr;
  logic stuff_due;

  fs_enc_seq #(
    .DATA_W      (DATA_W),
    .SYNC_LEN    (SYNC_LEN),
    .SYNC_PAT    (SYNC_PAT),
    .EOP_SE0_BITS(EOP_SE0_BITS),
    .GAP_BITS    (GAP_BITS)
  ) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_stb  (bit_stb),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_last  (in_last),
    .stuff_due(stuff_due),
    .in_ready (in_ready),
    .sym      (sym),
    .sym_bit  (sym_bit),
    .pay_adv  (pay_adv),
    .pay_clr  (pay_clr)
  );

  fs_enc_stuffer #(
    .RUN(STUFF_RUN)
  ) stuff_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (pay_clr),
    .adv      (pay_adv),
    .bit_val  (sym_bit),
    .stuff_due(stuff_due)
  );

  fs_enc_nrzi nrzi_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (bit_stb),
    .sym     (sym),
    .bit_val (sym_bit),
    .line_j  (line_j),
    .line_k  (line_k),
    .line_se0(line_se0),
    .line_oe (line_oe)
  );
endmodule

// File: rtl/fs_line_encoder_chk.sv
module fs_line_encoder_chk #(
  parameter int STUFF_RUN = 6
) (
  input logic clk,
  input logic rst_n,
  input logic bit_stb,
  input logic in_ready,
  input logic line_j,
  input logic line_k,
  input logic line_se0,
  input logic line_oe
);
  localparam int RW = $clog2(STUFF_RUN + 3);

  // Count consecutive unchanged coded periods (one count per held 1 bit).
  logic [RW-1:0] run_q;
  logic          prev_lvl_q;
  logic          prev_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= '0;
      prev_lvl_q <= 1'b1;
      prev_ok_q  <= 1'b0;
    end else if (bit_stb) begin
      if (line_oe && !line_se0) begin
        if (prev_ok_q && (line_j == prev_lvl_q)) run_q <= run_q + RW'(1);
        else                                     run_q <= '0;
        prev_lvl_q <= line_j;
        prev_ok_q  <= 1'b1;
      end else begin
        run_q     <= '0;
        prev_ok_q <= 1'b0;
      end
    end
  end

  // Sync ends with one held period; six payload ones may follow before a stuff.
  p_run_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(STUFF_RUN + 1));

  p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> ($countones({line_j, line_k, line_se0}) == 1));

  p_released_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !line_oe |-> !(line_j || line_k || line_se0));

  p_hold_between_strobes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable({line_j, line_k, line_se0, line_oe}));

  p_ready_on_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> bit_stb);

  p_no_ready_in_eop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_se0 |-> !in_ready);

  p_se0_followed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && line_se0) |=> (line_se0 || line_j));
endmodule

bind fs_line_encoder fs_line_encoder_chk #(.STUFF_RUN(STUFF_RUN)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .bit_stb (bit_stb),
  .in_ready(in_ready),
  .line_j  (line_j),
  .line_k  (line_k),
  .line_se0(line_se0),
  .line_oe (line_oe)
);

// File: tb/fs_line_encoder_tb_top.sv
module fs_line_encoder_tb_top;
  localparam int C_REL = 0, C_J = 1, C_K = 2, C_SE0 = 3, C_BAD = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_stb = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_last = 1'b0;
  logic       in_ready, line_j, line_k, line_se0, line_oe;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fs_line_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .line_j(line_j), .line_k(line_k), .line_se0(line_se0), .line_oe(line_oe)
  );

  function automatic int line_code();
    if (!line_oe) return (line_j || line_k || line_se0) ? C_BAD : C_REL;
    if (line_j && !line_k && !line_se0) return C_J;
    if (!line_j && line_k && !line_se0) return C_K;
    if (!line_j && !line_k && line_se0) return C_SE0;
    return C_BAD;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One bit period: strobe for one cycle, then one quiet cycle to check hold.
  task automatic bit_step(input logic v, input logic [7:0] d, input logic l,
                          output logic rdy, output int code);
    in_valid = v; in_data = d; in_last = l; bit_stb = 1'b1;
    #1 rdy = in_ready;
    @(negedge clk);
    bit_stb = 1'b0; in_valid = 1'b0;
    code = line_code();
    @(negedge clk);
    check("R8 hold", line_code(), code);
  endtask

  int    e_sym[$];
  int    e_rdy[$];
  string e_tag[$];

  task automatic push(input int s, input int r, input string t);
    e_sym.push_back(s); e_rdy.push_back(r); e_tag.push_back(t);
  endtask

  // Sends a packet; trunc withholds the last flag so the block must close on underflow.
  task automatic run_packet(input logic [7:0] pk[8], input int n, input bit trunc,
                            input logic [7:0] next_first);
    int lvl, ones, bi;
    logic rdy;
    int code;
    e_sym.delete(); e_rdy.delete(); e_tag.delete();
    lvl = 1;
    for (int i = 0; i < 8; i++) begin
      if (i != 7) lvl = 1 - lvl;
      push(lvl ? C_J : C_K, (i == 0) ? 1 : 0, "R2 sync");
    end
    ones = 0;
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 8; i++) begin
        if (ones == 6) begin
          lvl = 1 - lvl; ones = 0;
          push(lvl ? C_J : C_K, 0, "R4 stuff");
        end
        if (pk[k][i]) ones++;
        else begin ones = 0; lvl = 1 - lvl; end
        push(lvl ? C_J : C_K, (i == 0 && k > 0) ? 1 : 0, "R3 data");
      end
    end
    if (ones == 6) push((1 - lvl) ? C_J : C_K, 0, "R4 end stuff");
    push(C_SE0, trunc ? 1 : 0, trunc ? "R9 underflow" : "R6 eop");
    push(C_SE0, 0, "R6 eop");
    push(C_J, 0, "R6 eop");
    push(C_REL, 0, "R7 gap");
    push(C_REL, 0, "R7 gap");
    bi = 0;
    for (int s = 0; s < e_sym.size(); s++) begin
      logic v, l;
      logic [7:0] d;
      if (bi < n) begin
        v = 1'b1; d = pk[bi]; l = (bi == n - 1) && !trunc;
      end else begin
        // Offer the next packet early: must not be taken inside the gap (R7).
        v = (e_tag[s] == "R7 gap"); d = next_first; l = 1'b1;
      end
      bit_step(v, d, l, rdy, code);
      if (v && rdy && bi < n) bi++;
      check(e_tag[s], code, e_sym[s]);
      check((e_rdy[s] != 0) ? "R5 ready" : "R5 hold-off", int'(rdy), e_rdy[s]);
    end
    check("R5 bytes taken", bi, n);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] pk[8];
    for (int i = 0; i < 8; i++) pk[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 reset oe", int'(line_oe), 0);
    check("R1 reset lines", int'(line_j | line_k | line_se0), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle lines", line_code(), C_REL);
    check("R1 idle ready", int'(in_ready), 0);

    // Every single-byte packet, back to back.
    for (int b = 0; b < 256; b++) begin
      pk[0] = 8'(b);
      run_packet(pk, 1, 1'b0, 8'(b + 1));
    end
    // Two-byte sweep.
    for (int b = 0; b < 256; b++) begin
      pk[0] = 8'(b); pk[1] = 8'(b) ^ 8'hA5;
      run_packet(pk, 2, 1'b0, 8'h5A);
    end
    // Run of six ones straddling a byte boundary, then long runs.
    pk[0] = 8'hC0; pk[1] = 8'h0F; pk[2] = 8'hFF; pk[3] = 8'h00;
    run_packet(pk, 4, 1'b0, 8'hFF);
    for (int i = 0; i < 8; i++) pk[i] = 8'hFF;
    run_packet(pk, 8, 1'b0, 8'h00);
    pk[0] = 8'hE0; pk[1] = 8'h07; pk[2] = 8'hFC;
    run_packet(pk, 3, 1'b0, 8'h00);
    // Underflow: last flag withheld, plain and with a stuff pending.
    pk[0] = 8'h12;
    run_packet(pk, 1, 1'b1, 8'h00);
    pk[0] = 8'hFC;
    run_packet(pk, 1, 1'b1, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule